// File: doc/BRIEF.md
# Compare Match Timer Channel

A bank of identical timer channels behind a simple word-addressed register bus. Each channel owns a control/status register, an up-counter and a compare register. One shared run register holds a start bit per channel, and a shared free-running prescaler supplies four count rates taken from the bus clock.

A running channel advances once per selected prescaler tick. When the counter is equal to its compare value, the next count raises a sticky match flag. In periodic mode that count also returns the counter to zero, so one period is the compare value plus one ticks. In free mode the counter keeps climbing and wraps at all ones, which raises a sticky overflow flag.

The match flag drives an interrupt or a DMA request line, as the channel's request field selects. Software clears a flag by writing zero to it. A counter write lands only after two count-clock ticks, which mirrors a timer whose count clock is slow compared with the bus.

Top module: `cmt_top`

## Requirements
- R1: After reset every counter reads 0, every compare register reads all ones, every control register reads 0, the run register reads 0 and both request vectors are low.
- R2: The map is in word addresses. Bits [ADDR_W-1:2] select a block and bits [1:0] select a register in it. Block 0, index 0 is the run register. Block c+1 is channel c: index 0 is control, index 1 is the counter, index 2 is the compare register, and index 3 reads zero. Only control bits 15, 14, 8, 5:4 and 2:0 are stored; the other control bits read zero.
- R3: Channel c counts only while bit c of the run register is 1. While that bit is 0 the counter holds its value.
- R4: Bits 1:0 of the clock-select field set the count rate: 0 divides by 8, 1 by 32, 2 by 128 and 3 by 1. Bit 2 is stored but does not change the rate, so code 4 divides by 8 and code 7 by 1.
- R5: With control bit 8 at 1 (periodic mode), a count made while the counter equals the compare value returns the counter to zero and sets the match flag at control bit 15.
- R6: With control bit 8 at 0 (free mode), a count at the compare value sets the match flag and the counter continues upward. A count at all ones wraps the counter to zero and sets the overflow flag at control bit 14, unless that count is also a compare match.
- R7: The match and overflow flags stay set until a control write carries 0 in that flag's bit. Writing 1 to a flag leaves it unchanged.
- R8: Control bits 5:4 select the request type: 1 for DMA and 2 for interrupt; 0 and 3 select none. irq_o[c] is high while the match flag is set and the field is 2. dreq_o[c] is high while the match flag is set and the field is 1.
- R9: A counter write takes effect on the second count-clock tick after the write. Reads return the old value until then.
- R10: Writing 0 to a control register lowers that channel's requests, but the channel keeps counting (at divide-by-8) while its run bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and count source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| irq_o | output | NCH | Interrupt request per channel |
| dreq_o | output | NCH | DMA request per channel |

## Verification
The bench uses the default parameters: two channels, 32-bit counters and a 4-bit word address. With two channels it can show that one run bit gates one channel and leaves the other frozen. The full 32-bit counter width makes overflow and the all-ones compare wrap reachable only because the delayed counter write can preset the count just below all ones. The count-rate checks cover every ratio up to divide-by-128 using fixed windows of whole prescaler periods, so the result does not depend on the prescaler phase.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

  localparam int unsigned CSR_W      = 16;
  localparam int unsigned BIT_MATCH  = 15;
  localparam int unsigned BIT_OVER   = 14;
  localparam int unsigned BIT_PERIOD = 8;
  localparam int unsigned REQ_LO     = 4;
  localparam int unsigned CKS_LO     = 0;

  localparam logic [1:0] REQ_DMA = 2'd1;
  localparam logic [1:0] REQ_IRQ = 2'd2;

  localparam int unsigned NTAP = 3;
  localparam int unsigned PRE_W = 7;
  localparam int unsigned TAP_SHIFT [NTAP] = '{3, 5, 7};

  typedef enum logic [1:0] {
    IDX_CSR = 2'd0,
    IDX_CNT = 2'd1,
    IDX_CMP = 2'd2,
    IDX_RSV = 2'd3
  } reg_idx_e;

  typedef struct packed {
    logic       periodic;
    logic [1:0] req;
    logic [2:0] cks;
  } chan_cfg_t;

endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
  import cmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  output logic [NTAP:0]    tick_vec
);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;

  always_comb begin
    pre_d = pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    assign tick_vec[k] = &pre_q[TAP_SHIFT[k]-1:0];
  end

  assign tick_vec[NTAP] = 1'b1;

endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
  import cmt_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NTAP:0]     tick_vec,
  input  logic              run,
  input  logic              csr_we,
  input  logic              cnt_we,
  input  logic              cmp_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [CSR_W-1:0]  csr_rd,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [CNT_W-1:0]  cmp_q,
  output logic              cmf_q,
  output logic              ovf_q,
  output logic              pend_o,
  output logic              irq_o,
  output logic              dreq_o
);

  localparam logic [1:0] SETTLE = 2'd2;

  chan_cfg_t        cfg_q, cfg_d;
  logic [1:0]       wait_q, wait_d;
  logic [CNT_W-1:0] stage_q, stage_d;
  logic [CNT_W-1:0] cnt_d, cmp_d;
  logic             cmf_d, ovf_d;
  logic             tick, load_now, count_en;
  logic             at_cmp, at_top;
  logic             cnt_en, wait_en;

  // next-state logic
  always_comb begin
    tick     = tick_vec[cfg_q.cks[1:0]];
    load_now = tick && (wait_q == 2'd1);
    count_en = tick && run && !load_now;
    at_cmp   = (cnt_q == cmp_q);
    at_top   = &cnt_q;

    cfg_d.periodic = wdata[BIT_PERIOD];
    cfg_d.req      = wdata[REQ_LO +: 2];
    cfg_d.cks      = wdata[CKS_LO +: 3];

    cmp_d   = wdata[CNT_W-1:0];
    stage_d = wdata[CNT_W-1:0];

    wait_en = cnt_we || (tick && (wait_q != 2'd0));
    if (cnt_we) wait_d = SETTLE;
    else        wait_d = wait_q - 2'd1;

    cnt_en = load_now || count_en;
    if (load_now)                       cnt_d = stage_q;
    else if (at_cmp && cfg_q.periodic)  cnt_d = '0;
    else                                cnt_d = cnt_q + CNT_W'(1);

    cmf_d = (count_en && at_cmp) ||
            (csr_we ? (cmf_q && wdata[BIT_MATCH]) : cmf_q);
    ovf_d = (count_en && at_top && !at_cmp) ||
            (csr_we ? (ovf_q && wdata[BIT_OVER]) : ovf_q);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      wait_q  <= '0;
      stage_q <= '0;
      cnt_q   <= '0;
      cmp_q   <= '1;
      cmf_q   <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      if (csr_we)  cfg_q   <= cfg_d;
      if (wait_en) wait_q  <= wait_d;
      if (cnt_we)  stage_q <= stage_d;
      if (cnt_en)  cnt_q   <= cnt_d;
      if (cmp_we)  cmp_q   <= cmp_d;
      cmf_q <= cmf_d;
      ovf_q <= ovf_d;
    end
  end

  always_comb begin
    csr_rd = {cmf_q, ovf_q, 5'b0, cfg_q.periodic, 2'b0, cfg_q.req, 1'b0, cfg_q.cks};
    pend_o = (wait_q != 2'd0);
    irq_o  = cmf_q && (cfg_q.req == REQ_IRQ);
    dreq_o = cmf_q && (cfg_q.req == REQ_DMA);
  end

endmodule

// File: rtl/cmt_top.sv
module cmt_top
  import cmt_pkg::*;
#(
  parameter int unsigned NCH    = 2,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    irq_o,
  output logic [NCH-1:0]    dreq_o
);

  localparam int unsigned BLK_W = ADDR_W - 2;

  logic [1:0]        rs_q;
  logic              rst_int_n;
  logic [BLK_W-1:0]  blk;
  reg_idx_e          idx;
  logic              run_we;
  logic [NCH-1:0]    run_q, run_d;
  logic [NTAP:0]     tick_vec;

  logic [NCH-1:0][CSR_W-1:0] csr_arr;
  logic [NCH-1:0][CNT_W-1:0] cnt_arr;
  logic [NCH-1:0][CNT_W-1:0] cmp_arr;
  logic [NCH-1:0]            cmf_v, ovf_v, pend_v;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  always_comb begin
    blk    = bus_addr[ADDR_W-1:2];
    idx    = reg_idx_e'(bus_addr[1:0]);
    run_we = bus_we && (blk == '0) && (idx == IDX_CSR);
    run_d  = bus_wdata[NCH-1:0];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  run_q <= '0;
    else if (run_we) run_q <= run_d;
  end

  cmt_prescaler u_pre (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .tick_vec (tick_vec)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit = (blk == BLK_W'(c + 1));

    cmt_channel #(
      .CNT_W  (CNT_W),
      .DATA_W (DATA_W)
    ) u_ch (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .tick_vec (tick_vec),
      .run      (run_q[c]),
      .csr_we   (bus_we && hit && (idx == IDX_CSR)),
      .cnt_we   (bus_we && hit && (idx == IDX_CNT)),
      .cmp_we   (bus_we && hit && (idx == IDX_CMP)),
      .wdata    (bus_wdata),
      .csr_rd   (csr_arr[c]),
      .cnt_q    (cnt_arr[c]),
      .cmp_q    (cmp_arr[c]),
      .cmf_q    (cmf_v[c]),
      .ovf_q    (ovf_v[c]),
      .pend_o   (pend_v[c]),
      .irq_o    (irq_o[c]),
      .dreq_o   (dreq_o[c])
    );
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (blk == '0) begin
      if (idx == IDX_CSR) bus_rdata = DATA_W'(run_q);
    end
    for (int c = 0; c < NCH; c++) begin
      if (blk == BLK_W'(c + 1)) begin
        case (idx)
          IDX_CSR: bus_rdata = DATA_W'(csr_arr[c]);
          IDX_CNT: bus_rdata = DATA_W'(cnt_arr[c]);
          IDX_CMP: bus_rdata = DATA_W'(cmp_arr[c]);
          default: bus_rdata = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/cmt_checker.sv
module cmt_checker #(
  parameter int unsigned NCH    = 2,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      we,
  input logic [ADDR_W-1:0]         addr,
  input logic [DATA_W-1:0]         wdata,
  input logic [NCH-1:0]            run_q,
  input logic [NCH-1:0][CNT_W-1:0] cnt_arr,
  input logic [NCH-1:0]            cmf_v,
  input logic [NCH-1:0]            pend_v,
  input logic [NCH-1:0]            irq,
  input logic [NCH-1:0]            dreq
);

  localparam int unsigned BLK_W = ADDR_W - 2;

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    logic clr_match;
    assign clr_match = we && (addr == {BLK_W'(c + 1), 2'b00}) && !wdata[15];

    p_stop_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q[c] && !pend_v[c]) |=> $stable(cnt_arr[c]));

    p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(pend_v[c]) && (cnt_arr[c] != $past(cnt_arr[c])))
        |-> ((cnt_arr[c] == $past(cnt_arr[c]) + CNT_W'(1)) || (cnt_arr[c] == '0)));

    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmf_v[c] && !clr_match) |=> cmf_v[c]);

    p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[c] || dreq[c]) |-> cmf_v[c]);

    p_one_request_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq[c] && dreq[c]));
  end

endmodule

bind cmt_top cmt_checker #(
  .NCH    (NCH),
  .CNT_W  (CNT_W),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_int_n),
  .we      (bus_we),
  .addr    (bus_addr),
  .wdata   (bus_wdata),
  .run_q   (run_q),
  .cnt_arr (cnt_arr),
  .cmf_v   (cmf_v),
  .pend_v  (pend_v),
  .irq     (irq_o),
  .dreq    (dreq_o)
);

// File: tb/tb_cmt_top.sv
module tb_cmt_top;

  localparam int NCH = 2;
  localparam logic [3:0] A_RUN = 4'd0;
  localparam logic [3:0] A_CSR0 = 4'd4, A_CNT0 = 4'd5, A_CMP0 = 4'd6;
  localparam logic [3:0] A_CSR1 = 4'd8, A_CNT1 = 4'd9;

  // {write, addr, data}; for reads data is the expected value
  localparam logic [36:0] VEC [12] = '{
    {1'b0, 4'd0,  32'h0000_0000},
    {1'b0, 4'd4,  32'h0000_0000},
    {1'b0, 4'd5,  32'h0000_0000},
    {1'b0, 4'd6,  32'hFFFF_FFFF},
    {1'b0, 4'd10, 32'hFFFF_FFFF},
    {1'b0, 4'd7,  32'h0000_0000},
    {1'b1, 4'd6,  32'h0000_1234},
    {1'b0, 4'd6,  32'h0000_1234},
    {1'b1, 4'd8,  32'h0000_FFFF},
    {1'b0, 4'd8,  32'h0000_0137},
    {1'b1, 4'd8,  32'h0000_0000},
    {1'b0, 4'd8,  32'h0000_0000}
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           bus_we = 1'b0;
  logic [3:0]     bus_addr = '0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic [NCH-1:0] irq_o, dreq_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  cmt_top dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .dreq_o    (dreq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rate(input string tag, input logic [31:0] code, input int div, input int k);
    logic [31:0] a, b;
    wr(A_CSR0, code);
    rd(A_CNT0, a);
    idle(div * k);
    rd(A_CNT0, b);
    chk(tag, b - a, 32'(k));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] v, a, b, prev;
    int errs;

    idle(4);
    rst_n = 1'b1;
    idle(4);

    chk("R1 irq after reset", 32'(irq_o), 32'h0);
    chk("R1 dreq after reset", 32'(dreq_o), 32'h0);

    // R1 reset values and R2 register map from the vector table
    for (int i = 0; i < 12; i++) begin
      if (VEC[i][36]) wr(VEC[i][35:32], VEC[i][31:0]);
      else begin
        rd(VEC[i][35:32], v);
        chk(i < 5 ? "R1 reset readback" : "R2 map readback", v, VEC[i][31:0]);
      end
    end

    // R9 settling of a counter write (divide by 1, stopped)
    wr(A_CSR0, 32'h0000_0007);
    wr(A_CNT0, 32'h0000_ABCD);
    rd(A_CNT0, v); chk("R9 old value after write", v, 32'h0);
    idle(1);
    rd(A_CNT0, v); chk("R9 old value one tick later", v, 32'h0);
    idle(1);
    rd(A_CNT0, v); chk("R9 new value after two ticks", v, 32'h0000_ABCD);

    // R3 run bit gates each channel
    wr(A_CSR1, 32'h0000_0007);
    wr(A_RUN, 32'h1);
    rd(A_CNT0, a); idle(10); rd(A_CNT0, b);
    chk("R3 running channel advances", b - a, 32'd10);
    rd(A_CNT1, v); chk("R3 stopped channel holds", v, 32'h0);
    wr(A_RUN, 32'h0);
    rd(A_CNT0, a); idle(10); rd(A_CNT0, b);
    chk("R3 cleared run bit holds", b - a, 32'd0);

    // R4 count rates
    wr(A_RUN, 32'h1);
    rate("R4 code4 div8",   32'h4, 8,   5);
    rate("R4 code5 div32",  32'h5, 32,  3);
    rate("R4 code6 div128", 32'h6, 128, 2);
    rate("R4 code7 div1",   32'h7, 1,   9);
    rate("R4 code0 div8",   32'h0, 8,   4);
    rate("R4 code3 div1",   32'h3, 1,   6);

    // R5 periodic wrap at compare
    wr(A_RUN, 32'h0);
    wr(A_CMP0, 32'd5);
    wr(A_CSR0, 32'h0000_0107);
    wr(A_CNT0, 32'd0);
    idle(3);
    wr(A_RUN, 32'h1);
    errs = 0;
    rd(A_CNT0, prev);
    for (int i = 0; i < 20; i++) begin
      idle(1);
      rd(A_CNT0, v);
      if (v !== ((prev == 32'd5) ? 32'd0 : prev + 32'd1)) errs++;
      prev = v;
    end
    chk("R5 periodic sequence errors", 32'(errs), 32'd0);
    chk("R5 sequence stays below compare", 32'(prev <= 32'd5), 32'd1);
    rd(A_CSR0, v); chk("R5 match flag set", v, 32'h0000_8107);

    // R6 free mode: overflow, then match without wrap
    wr(A_RUN, 32'h0);
    wr(A_CSR0, 32'h0000_0007);
    wr(A_CMP0, 32'h10);
    wr(A_CNT0, 32'hFFFF_FFFC);
    idle(3);
    wr(A_RUN, 32'h1);
    idle(30);
    wr(A_RUN, 32'h0);
    rd(A_CSR0, v); chk("R6 overflow and match flags", v, 32'h0000_C007);
    rd(A_CNT0, v);
    chk("R6 counter continues past compare", 32'(v > 32'h10 && v < 32'h30), 32'd1);

    // R7 flag clear by zero, keep by one
    wr(A_CSR0, 32'h0000_8007);
    rd(A_CSR0, v); chk("R7 zero clears overflow, one keeps match", v, 32'h0000_8007);
    idle(5);
    rd(A_CSR0, v); chk("R7 flag stays set", v, 32'h0000_8007);
    wr(A_CSR0, 32'h0000_0007);
    rd(A_CSR0, v); chk("R7 zero clears match", v, 32'h0000_0007);

    // R6 wrap that is also a match sets no overflow
    wr(A_CSR0, 32'h0000_0107);
    wr(A_CMP0, 32'hFFFF_FFFF);
    wr(A_CNT0, 32'hFFFF_FFFE);
    idle(3);
    wr(A_RUN, 32'h1);
    idle(4);
    wr(A_RUN, 32'h0);
    rd(A_CSR0, v); chk("R6 match wrap without overflow", v, 32'h0000_8107);
    rd(A_CNT0, v); chk("R6 wrapped to low count", 32'(v < 32'd8), 32'd1);

    // R8 request routing
    wr(A_CSR0, 32'h0000_0127);
    wr(A_CMP0, 32'd3);
    wr(A_CNT0, 32'd0);
    idle(3);
    wr(A_RUN, 32'h1);
    idle(10);
    chk("R8 interrupt selected irq", 32'(irq_o), 32'h1);
    chk("R8 interrupt selected dreq", 32'(dreq_o), 32'h0);
    wr(A_CSR0, 32'h0000_8117);
    chk("R8 dma selected irq", 32'(irq_o), 32'h0);
    chk("R8 dma selected dreq", 32'(dreq_o), 32'h1);
    wr(A_CSR0, 32'h0000_8137);
    chk("R8 field 3 no requests", 32'({irq_o, dreq_o}), 32'h0);
    wr(A_CSR0, 32'h0000_8127);
    chk("R8 back to interrupt", 32'(irq_o), 32'h1);

    // R10 zero control write: no requests, counting goes on
    wr(A_CSR0, 32'h0);
    chk("R10 requests low after zero write", 32'({irq_o, dreq_o}), 32'h0);
    rd(A_CNT0, a); idle(24); rd(A_CNT0, b);
    chk("R10 still counting at div8", b - a, 32'd3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule